// File: doc/BRIEF.md
# Arithmetic Shift-Right Execution Unit

This unit takes one 32-bit instruction word together with the value of the operand register, the value of the shift-amount register and the current condition flags. From these it produces the result of a sign-preserving right shift, the destination register index, a write enable and the next flag values. The whole datapath is combinational and has no clock. The shift itself is a logarithmic barrel shifter. A guard bit below the operand catches the last bit that leaves the word. Amounts of one word width or more saturate to a word made entirely of sign bits.

Two instruction forms are accepted. In one, the amount comes from the low byte of a register. In the other, the amount is a 5-bit field inside the instruction word. The S bit of the instruction decides whether the N, Z and C flags take new values; V is never changed. Any word that matches neither form raises an illegal-encoding output. That word then causes no register write and no flag change. The condition field in bits [31:28] is not evaluated here.

Top module: `asr_exec_unit`

## Requirements
- R1: A word is the register form when bits [27:21]=0001101, bits [19:16]=0000, bit 7=0, bits [6:5]=10 and bit 4=1. Bit 20 is S, bits [15:12] are the destination index, bits [11:8] name the amount register and bits [3:0] name the operand register. Such a word does not raise illegal_o.
- R2: In the register form the amount is rs_val_i[7:0]; bits [31:8] of rs_val_i have no effect on any output.
- R3: An amount of 0 gives a result equal to the operand, and the carry-out equals the incoming C flag.
- R4: An amount k from 1 to 31 gives the operand shifted right by k with copies of operand bit 31 filled in from the left, and the carry-out is operand bit k-1.
- R5: An amount from 32 to 255 gives a result whose every bit equals operand bit 31, and the carry-out equals operand bit 31.
- R6: With S=1, N takes result bit 31, Z is 1 exactly when the result is zero, and C takes the carry-out. Flags are packed as {N,Z,C,V} in bits [3:0]. V is always passed through unchanged.
- R7: With S=0, flags_o equals flags_i.
- R8: A word is the immediate form when bit 4=0, bits [11:7] hold a 5-bit amount, and all other fields match R1. A field value of 0 means a shift of 32.
- R9: A word that matches neither form sets illegal_o=1, wr_en_o=0, result_o=0 and flags_o=flags_i.
- R10: For a legal word, wr_en_o=1 and rd_idx_o equals instruction bits [15:12].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of the operand register |
| rs_val_i | input | 32 | Value of the amount register (low byte used) |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 32 | Shift result (zero when illegal) |
| rd_idx_o | output | 4 | Destination register index |
| wr_en_o | output | 1 | Destination write enable |
| flags_o | output | 4 | Next flags {N,Z,C,V} |
| illegal_o | output | 1 | Word matches neither form |

## Verification
The embedded assertions are checked whenever the inputs are known. They cover the following: the saturation fill for large amounts, pass-through of the operand at amount zero, V never changing, flags holding when S is clear, an illegal word staying silent, and an immediate field of zero taking its carry from bit 31. The exact shifted value and carry for each of the 256 amounts, that the upper amount bits are ignored, and that the decoder rejects each single-bit corruption of the fixed fields can only be shown by the bench. It does this by sweeping every amount over corner and random operands and comparing against an arithmetic model.

// File: rtl/asr_pkg.sv
`timescale 1ns/1ps
package asr_pkg;

    localparam int XLEN      = 32;
    localparam int AMT_BITS  = 8;
    localparam int IMM_BITS  = 5;
    localparam int IDX_BITS  = 4;

    // fixed instruction fields shared by both forms
    localparam logic [6:0] OPC_FIELD   = 7'b0001101;
    localparam logic [3:0] ZERO_FIELD  = 4'b0000;
    localparam logic [1:0] SHIFT_ASR   = 2'b10;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef enum logic [1:0] {
        FORM_NONE = 2'd0,
        FORM_REG  = 2'd1,
        FORM_IMM  = 2'd2
    } form_e;

    typedef struct packed {
        form_e                 form;
        logic                  set_flags;
        logic [IDX_BITS-1:0]   rd;
        logic [IMM_BITS-1:0]   imm;
    } dec_t;

    // immediate field of zero encodes a full-word shift
    function automatic logic [AMT_BITS-1:0] imm_to_amount(input logic [IMM_BITS-1:0] imm);
        if (imm == '0) return AMT_BITS'(XLEN);
        return AMT_BITS'(imm);
    endfunction

endpackage

// File: rtl/asr_decode.sv
`timescale 1ns/1ps
module asr_decode
    import asr_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic common_ok;
    logic reg_ok;
    logic imm_ok;

    always_comb begin
        common_ok = (instr[27:21] == OPC_FIELD) &&
                    (instr[19:16] == ZERO_FIELD) &&
                    (instr[6:5]   == SHIFT_ASR);
        reg_ok    = common_ok && instr[4] && !instr[7];
        imm_ok    = common_ok && !instr[4];
    end

    always_comb begin
        dec           = '0;
        dec.form      = reg_ok ? FORM_REG : (imm_ok ? FORM_IMM : FORM_NONE);
        dec.set_flags = instr[20];
        dec.rd        = instr[15:12];
        dec.imm       = instr[11:7];
    end

endmodule

// File: rtl/asr_barrel.sv
`timescale 1ns/1ps
module asr_barrel #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] result,
    output logic              shifted_out
);

    localparam int CLIP_W = $clog2(DATA_W + 1);
    localparam int EXT_W  = DATA_W + 1;

    logic [CLIP_W-1:0] clip;
    logic [EXT_W-1:0]  stage [0:CLIP_W];

    // amounts of a word or more behave like exactly one word
    always_comb begin
        if (int'(amount) >= DATA_W) clip = CLIP_W'(DATA_W);
        else                        clip = CLIP_W'(amount);
    end

    // guard bit below the operand collects the last bit shifted out
    assign stage[0] = {operand, 1'b0};

    for (genvar i = 0; i < CLIP_W; i++) begin : g_stage
        localparam int STEP = 1 << i;
        if (STEP >= EXT_W) begin : g_full
            assign stage[i+1] = clip[i] ? {EXT_W{stage[i][EXT_W-1]}} : stage[i];
        end else begin : g_part
            assign stage[i+1] = clip[i] ?
                {{STEP{stage[i][EXT_W-1]}}, stage[i][EXT_W-1:STEP]} : stage[i];
        end
    end

    assign result      = stage[CLIP_W][EXT_W-1:1];
    assign shifted_out = stage[CLIP_W][0];

    always_comb begin
        if (!$isunknown({operand, amount})) begin
            p_sat_fill_r5: assert ((int'(amount) < DATA_W) ||
                                   (result == {DATA_W{operand[DATA_W-1]}}));
            p_zero_pass_r3: assert ((amount != '0) || (result == operand));
        end
    end

endmodule

// File: rtl/asr_flags.sv
`timescale 1ns/1ps
module asr_flags
    import asr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  flags_t            flags_in,
    input  logic              active,
    input  logic              set_flags,
    input  logic [DATA_W-1:0] result,
    input  logic              shifted_out,
    input  logic              amount_zero,
    output flags_t            flags_out
);

    logic carry;

    always_comb begin
        carry = amount_zero ? flags_in.c : shifted_out;
        flags_out = flags_in;
        if (active && set_flags) begin
            flags_out.n = result[DATA_W-1];
            flags_out.z = (result == '0);
            flags_out.c = carry;
        end
    end

    always_comb begin
        if (!$isunknown({flags_in, active, set_flags})) begin
            p_v_hold_r6: assert (flags_out.v == flags_in.v);
            p_no_update_r7: assert (!(active && !set_flags) || (flags_out == flags_in));
        end
    end

endmodule

// File: rtl/asr_exec_unit.sv
`timescale 1ns/1ps
module asr_exec_unit
    import asr_pkg::*;
(
    input  logic [31:0] instr_i,
    input  logic [31:0] rm_val_i,
    input  logic [31:0] rs_val_i,
    input  logic [3:0]  flags_i,
    output logic [31:0] result_o,
    output logic [3:0]  rd_idx_o,
    output logic        wr_en_o,
    output logic [3:0]  flags_o,
    output logic        illegal_o
);

    dec_t                 dec;
    logic                 legal;
    logic [AMT_BITS-1:0]  amount;
    logic [XLEN-1:0]      sh_result;
    logic                 sh_out;
    flags_t               fl_in;
    flags_t               fl_out;

    asr_decode u_decode (
        .instr (instr_i),
        .dec   (dec)
    );

    always_comb begin
        legal  = (dec.form != FORM_NONE);
        amount = (dec.form == FORM_REG) ? rs_val_i[AMT_BITS-1:0]
                                        : imm_to_amount(dec.imm);
    end

    asr_barrel #(
        .DATA_W (XLEN),
        .AMT_W  (AMT_BITS)
    ) u_barrel (
        .operand     (rm_val_i),
        .amount      (amount),
        .result      (sh_result),
        .shifted_out (sh_out)
    );

    assign fl_in = flags_t'(flags_i);

    asr_flags #(
        .DATA_W (XLEN)
    ) u_flags (
        .flags_in    (fl_in),
        .active      (legal),
        .set_flags   (dec.set_flags),
        .result      (sh_result),
        .shifted_out (sh_out),
        .amount_zero (amount == '0),
        .flags_out   (fl_out)
    );

    always_comb begin
        result_o  = legal ? sh_result : '0;
        rd_idx_o  = legal ? dec.rd : '0;
        wr_en_o   = legal;
        flags_o   = fl_out;
        illegal_o = !legal;
    end

    always_comb begin
        if (!$isunknown({instr_i, rm_val_i, rs_val_i, flags_i})) begin
            p_illegal_quiet_r9: assert (!illegal_o ||
                (!wr_en_o && (flags_o == flags_i) && (result_o == '0)));
            p_imm_zero_carry_r8: assert (!(!instr_i[4] && !illegal_o && instr_i[20] &&
                                           (instr_i[11:7] == 5'd0)) ||
                                         (flags_o[1] == rm_val_i[31]));
        end
    end

endmodule

// File: tb/asr_exec_unit_tb.sv
`timescale 1ns/1ps
module asr_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i  = '0;
    logic [31:0] rm_val_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [3:0]  flags_i  = '0;
    logic [31:0] result_o;
    logic [3:0]  rd_idx_o;
    logic        wr_en_o;
    logic [3:0]  flags_o;
    logic        illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    asr_exec_unit u_dut (
        .instr_i   (instr_i),
        .rm_val_i  (rm_val_i),
        .rs_val_i  (rs_val_i),
        .flags_i   (flags_i),
        .result_o  (result_o),
        .rd_idx_o  (rd_idx_o),
        .wr_en_o   (wr_en_o),
        .flags_o   (flags_o),
        .illegal_o (illegal_o)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_reg(input logic s, input logic [3:0] rd,
                                           input logic [3:0] rs, input logic [3:0] rm);
        return {4'hE, 7'b0001101, s, 4'b0000, rd, rs, 1'b0, 2'b10, 1'b1, rm};
    endfunction

    function automatic logic [31:0] mk_imm(input logic s, input logic [3:0] rd,
                                           input logic [4:0] imm, input logic [3:0] rm);
        return {4'hE, 7'b0001101, s, 4'b0000, rd, imm, 2'b10, 1'b0, rm};
    endfunction

    // arithmetic reference: signed shift and last-bit-out rule
    function automatic logic [31:0] ref_res(input logic [31:0] op, input int amt);
        return 32'($signed(op) >>> amt);
    endfunction

    function automatic logic ref_carry(input logic [31:0] op, input int amt, input logic cin);
        if (amt == 0) return cin;
        if (amt < 32) return op[amt-1];
        return op[31];
    endfunction

    function automatic logic [3:0] ref_flags(input logic [31:0] op, input int amt,
                                             input logic [3:0] fin, input logic s);
        logic [31:0] r;
        r = ref_res(op, amt);
        if (!s) return fin;
        return {r[31], (r == 32'd0), ref_carry(op, amt, fin[1]), fin[0]};
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [31:0] rm,
                         input logic [31:0] rs, input logic [3:0] fl);
        @(negedge clk);
        instr_i  = ins;
        rm_val_i = rm;
        rs_val_i = rs;
        flags_i  = fl;
        #1;
    endtask

    function automatic string amt_tag(input int amt);
        if (amt == 0) return "R3";
        if (amt < 32) return "R4";
        return "R5";
    endfunction

    logic [31:0] ops [0:7];

    initial begin
        ops[0] = 32'h0000_0000;
        ops[1] = 32'hFFFF_FFFF;
        ops[2] = 32'h8000_0000;
        ops[3] = 32'h7FFF_FFFF;
        for (int i = 4; i < 8; i++) ops[i] = $urandom();

        repeat (2) @(posedge clk);
        rst = 1'b0;

        // idle state: all-zero word is not a valid encoding (R9)
        drive('0, '0, '0, 4'b0000);
        chk("R9 idle illegal", {63'd0, illegal_o}, 64'd1);
        chk("R9 idle no write", {63'd0, wr_en_o}, 64'd0);

        // register form: every amount, corner and random operands
        for (int o = 0; o < 8; o++) begin
            for (int amt = 0; amt < 256; amt++) begin
                logic [31:0] rs;
                logic [3:0]  fl;
                logic [3:0]  rd;
                logic [31:0] rnd;
                rnd = $urandom();
                rs  = {rnd[31:8], 8'(amt)};
                fl  = 4'($urandom());
                rd  = 4'($urandom());
                drive(mk_reg(1'b1, rd, 4'd3, 4'd5), ops[o], rs, fl);
                chk({amt_tag(amt), " reg result"}, {32'd0, result_o}, {32'd0, ref_res(ops[o], amt)});
                chk({amt_tag(amt), " R6 reg flags"}, {60'd0, flags_o}, {60'd0, ref_flags(ops[o], amt, fl, 1'b1)});
                chk("R1 R10 reg legal", {58'd0, illegal_o, wr_en_o, rd_idx_o}, {58'd0, 1'b0, 1'b1, rd});
            end
        end

        // R2: upper bits of the amount register ignored
        drive(mk_reg(1'b1, 4'd1, 4'd2, 4'd3), 32'h8765_4321, 32'hFFFF_FF00, 4'b0010);
        chk("R2 upper bits ignored result", {32'd0, result_o}, {32'd0, 32'h8765_4321});
        chk("R2 upper bits ignored flags", {60'd0, flags_o}, {60'd0, 4'b1010});
        drive(mk_reg(1'b1, 4'd1, 4'd2, 4'd3), 32'h8765_4321, 32'h0000_0104, 4'b0000);
        chk("R2 low byte four", {32'd0, result_o}, {32'd0, 32'hF876_5432});

        // immediate form, both S values
        for (int o = 0; o < 8; o++) begin
            for (int imm = 0; imm < 32; imm++) begin
                for (int s = 0; s < 2; s++) begin
                    int          eff;
                    logic [3:0]  fl;
                    fl  = 4'($urandom());
                    eff = (imm == 0) ? 32 : imm;
                    drive(mk_imm(1'(s), 4'd9, 5'(imm), 4'd7), ops[o], $urandom(), fl);
                    chk("R8 imm result", {32'd0, result_o}, {32'd0, ref_res(ops[o], eff)});
                    chk(s ? "R8 R6 imm flags" : "R7 flags held", {60'd0, flags_o},
                        {60'd0, ref_flags(ops[o], eff, fl, 1'(s))});
                    chk("R10 imm write", {58'd0, illegal_o, wr_en_o, rd_idx_o}, {58'd0, 1'b0, 1'b1, 4'd9});
                end
            end
        end

        // R7 on register form
        drive(mk_reg(1'b0, 4'd4, 4'd2, 4'd3), 32'h8000_0001, 32'd1, 4'b0101);
        chk("R7 reg flags held", {60'd0, flags_o}, {60'd0, 4'b0101});
        chk("R7 reg result still written", {32'd0, result_o}, {32'd0, 32'hC000_0000});

        // R9: corrupt each fixed bit of the register form
        begin
            int pos [0:13] = '{27, 26, 25, 24, 23, 22, 21, 19, 18, 17, 16, 7, 6, 5};
            for (int k = 0; k < 14; k++) begin
                logic [31:0] w;
                logic [3:0]  fl;
                w  = mk_reg(1'b1, 4'd6, 4'd2, 4'd3);
                w[pos[k]] = ~w[pos[k]];
                fl = 4'($urandom());
                drive(w, 32'hDEAD_BEEF, 32'd4, fl);
                chk("R9 corrupt illegal", {62'd0, illegal_o, wr_en_o}, {62'd0, 1'b1, 1'b0});
                chk("R9 corrupt flags held", {60'd0, flags_o}, {60'd0, fl});
                chk("R9 corrupt result zero", {32'd0, result_o}, 64'd0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule